// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This unit gathers the condition flags of an SD host controller into one status word. Ten event strobes from the command path, the data path and the FIFO each set a sticky flag. A card-change flag is set inside the unit whenever the synchronised card-presence level changes. Two further status bits are not sticky: they show the synchronised card-presence level and the synchronised write-protect level as they are now.

Software uses a small word-addressed register port. It reads the status word. It acknowledges flags by writing ones to a separate clear word. It selects which sticky flags may raise the interrupt through a mask word, which has the same bit layout as the clear word. The level interrupt output is the registered OR of all sticky flags that are unmasked. During block reads, the FIFO overrun flag means data is waiting in the FIFO. During block writes, the FIFO underrun flag means the FIFO has room for more data.

Top module: `sdh_evt_unit`

## Requirements
- R1: After reset the sticky flags (status bits 10:0) read 0, the mask word reads 0 and irq_o is low.
- R2: A high on evt_i[k] (k = 0..9) at a clock edge sets status bit k, and it is readable from the next cycle on. The bit stays set after the strobe drops. Bit meanings: 0 response CRC fail, 1 data CRC fail, 2 response timeout, 3 data timeout, 4 response CRC ok, 5 data CRC ok, 6 command sent, 7 data end, 8 FIFO underrun, 9 FIFO overrun.
- R3: A write to word address 11 (the clear word) clears each sticky bit whose written data bit is 1. Written zeros change nothing.
- R4: When a bit is set by an event and cleared by a write in the same cycle, the bit ends up set.
- R5: Word address 12 holds the mask in bits 10:0. It reads back what was written, with bits 31:11 reading 0. It changes only when written.
- R6: irq_o equals the OR over bits 10:0 of (sticky AND mask) as it was one cycle earlier.
- R7: Status bit 11 shows card_absent_i (1 = no card) and status bit 12 shows wr_prot_i. Each passes through a two-flop synchroniser and appears two cycles after the input changes. Clear-word writes do not affect these two bits.
- R8: Any change of the synchronised card-absent level sets sticky status bit 10 (card change) one cycle after the new level appears in bit 11.
- R9: Word address 10 is the status word, and writes to it are ignored. Reads of the clear word or of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| evt_i | input | 10 | Event strobes for sticky bits 9:0 |
| card_absent_i | input | 1 | Card-presence level, 1 when no card |
| wr_prot_i | input | 1 | Write-protect level |
| irq_o | output | 1 | Level interrupt |

## Verification
A sticky bit that is lost or set wrongly shows up in the status word one cycle after the edge that caused it. If that bit is unmasked, it also shows on irq_o one cycle later. A wrong mask or clear decode shows up as an interrupt that stays stuck high or never rises. The synchroniser depth is pinned exactly, and so is the one-cycle lag of the card-change flag behind the level bit. Simultaneous set and clear, and writes to read-only words, are driven on purpose. A behavioural model is compared with both outputs on every clock, including during a random phase.

// File: rtl/sdh_evt_pkg.sv
package sdh_evt_pkg;
  localparam int EXT_EVT_W = 10;          // externally strobed events
  localparam int STICKY_W  = 11;          // plus card change
  localparam int CHG_BIT   = 10;
  localparam int CD_BIT    = 11;
  localparam int WP_BIT    = 12;
  localparam int STAT_WA   = 10;
  localparam int CLR_WA    = 11;
  localparam int MASK_WA   = 12;
endpackage

// File: rtl/sdh_evt_sync.sv
module sdh_evt_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sdh_evt_edge.sv
module sdh_evt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic chg_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/sdh_evt_sticky.sv
module sdh_evt_sticky #(
  parameter int N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[k]) bit_q <= 1'b1;   // set has priority
      else if (clr_i[k]) bit_q <= 1'b0;
    end
    assign q_o[k] = bit_q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);  // R4
    AST_CLR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);  // R3
    AST_ROSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(q_o[k]) |-> $past(set_i[k]));  // R2
  end
endmodule

// File: rtl/sdh_evt_unit.sv
module sdh_evt_unit
  import sdh_evt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EXT_EVT_W-1:0] evt_i,
  input  logic              card_absent_i,
  input  logic              wr_prot_i,
  output logic              irq_o
);
  logic [1:0]          lvl_s;
  logic                cd_s, wp_s, cd_chg;
  logic [STICKY_W-1:0] sticky, set_v, clr_v, mask_q;
  logic                irq_q;
  logic                clr_hit, mask_hit;
  logic [DATA_W-1:0]   stat_w;
  logic                wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:STICKY_W];

  sdh_evt_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_prot_i, card_absent_i}),
    .q_o   (lvl_s)
  );
  assign cd_s = lvl_s[0];
  assign wp_s = lvl_s[1];

  sdh_evt_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cd_s),
    .chg_o (cd_chg)
  );

  assign clr_hit  = we_i && (addr_i == ADDR_W'(CLR_WA));
  assign mask_hit = we_i && (addr_i == ADDR_W'(MASK_WA));
  assign set_v    = {cd_chg, evt_i};
  assign clr_v    = clr_hit ? wdata_i[STICKY_W-1:0] : '0;

  sdh_evt_sticky #(.N(STICKY_W)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (sticky)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_hit) mask_q <= wdata_i[STICKY_W-1:0];
      irq_q <= |(sticky & mask_q);
    end
  end
  assign irq_o = irq_q;

  always_comb begin
    stat_w                 = '0;
    stat_w[STICKY_W-1:0]   = sticky;
    stat_w[CD_BIT]         = cd_s;
    stat_w[WP_BIT]         = wp_s;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(STAT_WA))      rdata_o = stat_w;
    else if (addr_i == ADDR_W'(MASK_WA)) rdata_o[STICKY_W-1:0] = mask_q;
  end

  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(sticky & mask_q)));  // R6
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_hit |=> $stable(mask_q));  // R5
  AST_CD_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_s != $past(cd_s)) |-> sticky[CHG_BIT] || cd_chg);  // R8
  AST_CHG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_chg |=> sticky[CHG_BIT]);  // R8
endmodule

// File: tb/sdh_evt_unit_bench.sv
module sdh_evt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = 5'd10;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        cd = 1'b0;
  logic        wp = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdh_evt_unit u_sdh_evt_unit (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .card_absent_i(cd), .wr_prot_i(wp), .irq_o(irq)
  );

  // behavioural reference
  int m_sticky, m_mask, m_irq, m_cd1, m_cd2, m_cdp, m_wp1, m_wp2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sticky = 0; m_mask = 0; m_irq = 0;
      m_cd1 = 0; m_cd2 = 0; m_cdp = 0; m_wp1 = 0; m_wp2 = 0;
    end else begin
      int setm, clrm;
      setm = int'(evt);
      if (m_cd2 != m_cdp) setm = setm + 1024;
      clrm = (we && addr == 11) ? int'(wdata) & 'h7FF : 0;
      m_irq = ((m_sticky & m_mask) != 0) ? 1 : 0;
      m_sticky = (m_sticky & ~clrm) | setm;
      if (we && addr == 12) m_mask = int'(wdata) & 'h7FF;
      m_cdp = m_cd2; m_cd2 = m_cd1; m_cd1 = int'(cd);
      m_wp2 = m_wp1; m_wp1 = int'(wp);
    end
  end

  function automatic int model_read(input int a);
    if (a == 10) return m_sticky | (m_cd2 << 11) | (m_wp2 << 12);
    if (a == 12) return m_mask;
    return 0;
  endfunction

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      checks++;
      if (int'(irq) != m_irq) begin
        errors++;
        $display("FAIL R6 irq per-cycle act=%0d exp=%0d", irq, m_irq);
      end
      checks++;
      if (int'(rdata) != model_read(int'(addr))) begin
        errors++;
        $display("FAIL R9 read addr=%0d act=%h exp=%h", addr, rdata, model_read(int'(addr)));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = 5'(a); wdata = d;
    step();
    we = 1'b0; addr = 5'd10; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    addr = 5'(a); #1;
    chk(req, rdata, exp);
    addr = 5'd10;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd_chk("R1 status", 10, 32'h0);
    rd_chk("R1 mask", 12, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 sticky set
    evt = 10'h005; step(); evt = '0;
    rd_chk("R2 set", 10, 32'h005);
    step();
    rd_chk("R2 sticky hold", 10, 32'h005);

    // R5/R6 mask and irq lag
    wr(12, 32'h4);
    rd_chk("R5 mask rd", 12, 32'h4);
    chk("R6 irq lag", {31'b0, irq}, 32'h0);
    step();
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    wr(12, 32'hFFFF_FFFF);
    rd_chk("R5 upper zero", 12, 32'h7FF);
    wr(12, 32'h4);

    // R3 clear
    wr(11, 32'h1);
    rd_chk("R3 clear one", 10, 32'h004);
    wr(11, 32'h0);
    rd_chk("R3 zeros ignored", 10, 32'h004);
    wr(11, 32'h4);
    rd_chk("R3 clear two", 10, 32'h000);
    chk("R6 irq still high", {31'b0, irq}, 32'h1);
    step();
    chk("R6 irq drops", {31'b0, irq}, 32'h0);

    // R4 set wins
    evt = 10'h008; we = 1'b1; addr = 5'd11; wdata = 32'h8;
    step();
    evt = '0; we = 1'b0; addr = 5'd10; wdata = '0;
    rd_chk("R4 set wins", 10, 32'h008);
    wr(11, 32'h8);

    // R7/R8 card detect sync and change
    cd = 1'b1;
    step(); rd_chk("R7 sync stage1", 10, 32'h000);
    step(); rd_chk("R7 sync stage2", 10, 32'h800);
    step(); rd_chk("R8 change flag", 10, 32'hC00);
    wr(11, 32'h400);
    rd_chk("R8 change cleared", 10, 32'h800);
    wr(11, 32'h1800);
    rd_chk("R7 level not cleared", 10, 32'h800);
    wp = 1'b1;
    step(); step();
    rd_chk("R7 write protect", 10, 32'h1800);
    cd = 1'b0;
    step(); step(); step();
    rd_chk("R8 removal change", 10, 32'h1400);

    // R9 map
    rd_chk("R9 clear reads 0", 11, 32'h0);
    rd_chk("R9 unmapped", 0, 32'h0);
    wr(10, 32'h7FF);
    rd_chk("R9 status write ignored", 10, 32'h1400);
    wr(11, 32'h7FF);

    // random phase, compared per cycle
    for (int i = 0; i < 600; i++) begin
      evt = 10'($urandom) & 10'($urandom);
      we = ($urandom % 3) == 0;
      addr = 5'(10 + ($urandom % 4));
      wdata = $urandom;
      if (($urandom % 16) == 0) cd = ~cd;
      if (($urandom % 16) == 0) wp = ~wp;
      step();
    end
    we = 1'b0; evt = '0; addr = 5'd10;
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule